// File: doc/BRIEF.md
# Multi-Format Instruction Decoder

This block is a purely combinational decoder for 16-bit instruction words. The two lowest bits of the word pick one of several field layouts. The decoder then produces one 5-bit opcode for every layout. The immediate form and the register form of the same operation therefore reach the execute stage as the same opcode, and the opcode bits missing from the immediate layouts are rebuilt from the layout code.

Alongside the opcode the decoder supplies the destination and source register indices, flags that mark immediate and prefix words, and an illegal-instruction flag. It also produces the right-hand operand. That operand is one of three things:
- the value read from the source register, which the register file returns on an input;
- the sign-extended immediate;
- when an upper-immediate prefix is pending, the 12 prefix bits joined to the low four bits of the current immediate.

Whether a prefix is pending, and its value, are held outside this block.

Top module: `insn_decoder`

## Requirements
- R1: Layout code 11 (bits 1:0) is register-immediate arithmetic. The opcode is 16 plus the 4-bit function in bits 5:2, rd is bits 15:12, rs reads 0, the operand is the sign-extended 6-bit field in bits 11:6, and the immediate flag is 1.
- R2: Layout code 00 is register-register. The opcode is bits 6:2, rd is bits 15:12 and rs is bits 11:8. The operand equals the register value input, the immediate flag is 0, and bit 7 has no effect.
- R3: A register-register word with opcode 0, 1, 2 or 3 carries no operands: rd, rs and the operand all read 0.
- R4: Low nibble 0001 gives opcode 6 and low nibble 1001 gives opcode 7. Both take rd from bits 15:12 and use an operand that is the sign-extended 8-bit field in bits 11:4.
- R5: Low five bits 00101 give opcode 8. Its operand is the sign-extended 11-bit field in bits 15:5, and rd and rs read 0.
- R6: Low nibble 1101 is the upper-immediate prefix. It gives opcode 9 with both the prefix flag and the immediate flag set, and its operand is bits 15:4 followed by four zero bits, whether or not a prefix is pending.
- R7: A register-register word with opcode 9 or 11 carries no operands. With FOLD_ALIAS=1 opcode 11 is reported as 9; with FOLD_ALIAS=0 it is reported as 11.
- R8: While a prefix is pending, every non-prefix immediate form uses as its operand the 12 prefix bits followed by the low four bits of its own immediate field.
- R9: A pending prefix has no effect on the operand of register-register words.
- R10: Layout code 10, and low five bits 10101, are illegal. Such a word raises the illegal flag and decodes as opcode 0 with the immediate and prefix flags at 0 and rd, rs and the operand at 0.
- R11: Every word of a defined layout leaves the illegal flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 16 | Instruction word |
| pfx_pending_i | input | 1 | An upper-immediate prefix applies to this word |
| pfx_val_i | input | 12 | Pending prefix bits |
| rs_val_i | input | 16 | Value read from register rs |
| opcode_o | output | 5 | Unified opcode |
| rd_idx_o | output | 4 | Destination register index |
| rs_idx_o | output | 4 | Source register index |
| rsval_o | output | 16 | Right-hand operand |
| is_imm_o | output | 1 | Word uses an immediate |
| is_prefix_o | output | 1 | Word is the upper-immediate prefix |
| illegal_o | output | 1 | Word matches no defined layout |

## Verification
The bench builds two copies of the decoder with the default widths. One keeps FOLD_ALIAS=1 and the other sets FOLD_ALIAS=0, so both variants of the opcode 11 alias are checked side by side on the same words. The default widths let the vector table cover every layout, the extreme values of each signed immediate field, and the prefix splice with a fixed prefix pattern. The splice is applied to every immediate form, and the same prefix is also driven against register words and illegal words.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
   typedef enum logic [2:0] {
      FK_NONE,
      FK_ALU_I,
      FK_REG,
      FK_MOVE_I,
      FK_LDC_I,
      FK_JMP_I,
      FK_PFX
   } fmt_kind_e;

   localparam int OP_MOVE    = 6;
   localparam int OP_LDC     = 7;
   localparam int OP_JMP     = 8;
   localparam int OP_IMM_PFX = 9;
   localparam int OP_ALIAS   = 11;
   localparam int OP_NOOPND  = 4;
endpackage

// File: rtl/insn_fmt_classify.sv
module insn_fmt_classify
   import insn_dec_pkg::*;
#(
   parameter int OP_W       = 5,
   parameter bit FOLD_ALIAS = 1'b1
) (
   input  logic [6:0]      insn_lo,
   output fmt_kind_e       kind,
   output logic [OP_W-1:0] opcode,
   output logic            no_opnd
);
   logic [OP_W-1:0] reg_op;
   logic [4:0]      raw_op;

   assign raw_op = insn_lo[6:2];

   generate
      if (FOLD_ALIAS) begin : g_fold
         assign reg_op = (raw_op == 5'(OP_ALIAS)) ? OP_W'(OP_IMM_PFX) : OP_W'(raw_op);
      end else begin : g_keep
         assign reg_op = OP_W'(raw_op);
      end
   endgenerate

   always_comb begin
      kind = FK_NONE;
      unique case (insn_lo[1:0])
         2'b11: kind = FK_ALU_I;
         2'b00: kind = FK_REG;
         2'b01: begin
            unique case (insn_lo[3:2])
               2'b00: kind = FK_MOVE_I;
               2'b10: kind = FK_LDC_I;
               2'b11: kind = FK_PFX;
               default: kind = insn_lo[4] ? FK_NONE : FK_JMP_I;
            endcase
         end
         default: kind = FK_NONE;
      endcase
   end

   always_comb begin
      opcode = '0;
      unique case (kind)
         FK_ALU_I:  opcode = {1'b1, insn_lo[5:2]};
         FK_REG:    opcode = reg_op;
         FK_MOVE_I: opcode = OP_W'(OP_MOVE);
         FK_LDC_I:  opcode = OP_W'(OP_LDC);
         FK_JMP_I:  opcode = OP_W'(OP_JMP);
         FK_PFX:    opcode = OP_W'(OP_IMM_PFX);
         default:   opcode = '0;
      endcase
   end

   assign no_opnd = (kind == FK_REG) &&
                    ((raw_op < 5'(OP_NOOPND)) || (raw_op == 5'(OP_IMM_PFX)) ||
                     (raw_op == 5'(OP_ALIAS)));
endmodule

// File: rtl/insn_field_extract.sv
module insn_field_extract
   import insn_dec_pkg::*;
#(
   parameter int INSN_W = 16,
   parameter int REG_W  = 4,
   parameter int DATA_W = 16,
   parameter int LOW_W  = 4
) (
   input  logic [INSN_W-1:4]  insn_hi,
   input  fmt_kind_e          kind,
   input  logic               no_opnd,
   output logic [REG_W-1:0]   rd_idx,
   output logic [REG_W-1:0]   rs_idx,
   output logic [DATA_W-1:0]  imm_ext,
   output logic [LOW_W-1:0]   imm_lo
);
   always_comb begin
      rd_idx  = '0;
      rs_idx  = '0;
      imm_ext = '0;
      imm_lo  = '0;
      unique case (kind)
         FK_ALU_I: begin
            rd_idx  = insn_hi[15:12];
            imm_ext = {{(DATA_W-6){insn_hi[11]}}, insn_hi[11:6]};
            imm_lo  = insn_hi[9:6];
         end
         FK_REG: begin
            if (!no_opnd) begin
               rd_idx = insn_hi[15:12];
               rs_idx = insn_hi[11:8];
            end
         end
         FK_MOVE_I, FK_LDC_I: begin
            rd_idx  = insn_hi[15:12];
            imm_ext = {{(DATA_W-8){insn_hi[11]}}, insn_hi[11:4]};
            imm_lo  = insn_hi[7:4];
         end
         FK_JMP_I: begin
            imm_ext = {{(DATA_W-11){insn_hi[15]}}, insn_hi[15:5]};
            imm_lo  = insn_hi[8:5];
         end
         FK_PFX: begin
            imm_ext = {insn_hi[15:4], {LOW_W{1'b0}}};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/insn_rhs_select.sv
module insn_rhs_select
   import insn_dec_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PFX_W  = 12,
   parameter int LOW_W  = 4
) (
   input  fmt_kind_e          kind,
   input  logic               no_opnd,
   input  logic [DATA_W-1:0]  imm_ext,
   input  logic [LOW_W-1:0]   imm_lo,
   input  logic               pfx_pending,
   input  logic [PFX_W-1:0]   pfx_val,
   input  logic [DATA_W-1:0]  rs_val,
   output logic [DATA_W-1:0]  rsval,
   output logic               is_imm,
   output logic               is_prefix
);
   always_comb begin
      is_imm    = 1'b0;
      is_prefix = 1'b0;
      rsval     = '0;
      unique case (kind)
         FK_REG:  rsval = no_opnd ? '0 : rs_val;
         FK_PFX: begin
            is_imm    = 1'b1;
            is_prefix = 1'b1;
            rsval     = imm_ext;
         end
         FK_ALU_I, FK_MOVE_I, FK_LDC_I, FK_JMP_I: begin
            is_imm = 1'b1;
            rsval  = pfx_pending ? {pfx_val, imm_lo} : imm_ext;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
   import insn_dec_pkg::*;
#(
   parameter int INSN_W     = 16,
   parameter int OP_W       = 5,
   parameter int REG_W      = 4,
   parameter int PFX_W      = 12,
   parameter int DATA_W     = 16,
   parameter bit FOLD_ALIAS = 1'b1
) (
   input  logic [INSN_W-1:0] insn_i,
   input  logic              pfx_pending_i,
   input  logic [PFX_W-1:0]  pfx_val_i,
   input  logic [DATA_W-1:0] rs_val_i,
   output logic [OP_W-1:0]   opcode_o,
   output logic [REG_W-1:0]  rd_idx_o,
   output logic [REG_W-1:0]  rs_idx_o,
   output logic [DATA_W-1:0] rsval_o,
   output logic              is_imm_o,
   output logic              is_prefix_o,
   output logic              illegal_o
);
   localparam int LOW_W = DATA_W - PFX_W;

   generate
      if (INSN_W != 16) begin : g_bad_insn
         $error("insn_decoder: field layout needs INSN_W = 16");
      end
      if (OP_W != 5) begin : g_bad_op
         $error("insn_decoder: opcode space needs OP_W = 5");
      end
      if (REG_W != 4) begin : g_bad_reg
         $error("insn_decoder: register fields need REG_W = 4");
      end
      if (LOW_W != 4) begin : g_bad_split
         $error("insn_decoder: prefix splice needs DATA_W - PFX_W = 4");
      end
   endgenerate

   fmt_kind_e         kind;
   logic              no_opnd;
   logic [DATA_W-1:0] imm_ext;
   logic [LOW_W-1:0]  imm_lo;

   insn_fmt_classify #(.OP_W(OP_W), .FOLD_ALIAS(FOLD_ALIAS)) u_classify (
      .insn_lo (insn_i[6:0]),
      .kind    (kind),
      .opcode  (opcode_o),
      .no_opnd (no_opnd)
   );

   insn_field_extract #(.INSN_W(INSN_W), .REG_W(REG_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_fields (
      .insn_hi (insn_i[INSN_W-1:4]),
      .kind    (kind),
      .no_opnd (no_opnd),
      .rd_idx  (rd_idx_o),
      .rs_idx  (rs_idx_o),
      .imm_ext (imm_ext),
      .imm_lo  (imm_lo)
   );

   insn_rhs_select #(.DATA_W(DATA_W), .PFX_W(PFX_W), .LOW_W(LOW_W)) u_rhs (
      .kind        (kind),
      .no_opnd     (no_opnd),
      .imm_ext     (imm_ext),
      .imm_lo      (imm_lo),
      .pfx_pending (pfx_pending_i),
      .pfx_val     (pfx_val_i),
      .rs_val      (rs_val_i),
      .rsval       (rsval_o),
      .is_imm      (is_imm_o),
      .is_prefix   (is_prefix_o)
   );

   assign illegal_o = (kind == FK_NONE);

   always_comb begin
      // R10
      illegal_nop_chk: assert (!illegal_o || (opcode_o == '0 && !is_imm_o && !is_prefix_o && rsval_o == '0))
         else $error("illegal word did not decode as nop");
      // R6
      prefix_op_chk: assert (!is_prefix_o || (is_imm_o && opcode_o == OP_W'(OP_IMM_PFX)))
         else $error("prefix word with wrong opcode or flags");
      // R1
      alu_imm_group_chk: assert (kind != FK_ALU_I || opcode_o[OP_W-1])
         else $error("arithmetic immediate outside upper opcode half");
      // R8
      pfx_splice_chk: assert (!(pfx_pending_i && is_imm_o && !is_prefix_o) || rsval_o[DATA_W-1:LOW_W] == pfx_val_i)
         else $error("pending prefix not spliced into operand");
      // R9
      reg_rhs_chk: assert (!(kind == FK_REG && !no_opnd) || rsval_o == rs_val_i)
         else $error("register operand not passed through");
      // R3
      no_opnd_chk: assert (!no_opnd || (rd_idx_o == '0 && rs_idx_o == '0 && rsval_o == '0))
         else $error("operand-free word exposed fields");
   end
endmodule

// File: tb/insn_decoder_tb.sv
module insn_decoder_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [15:0] insn;
   logic        pend;
   logic [11:0] pfx;
   logic [15:0] rsv;
   logic [4:0]  op_a, op_b;
   logic [3:0]  rd_a, rs_a, rd_b, rs_b;
   logic [15:0] val_a, val_b;
   logic        imm_a, pf_a, ill_a, imm_b, pf_b, ill_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   insn_decoder u_dut (
      .insn_i(insn), .pfx_pending_i(pend), .pfx_val_i(pfx), .rs_val_i(rsv),
      .opcode_o(op_a), .rd_idx_o(rd_a), .rs_idx_o(rs_a), .rsval_o(val_a),
      .is_imm_o(imm_a), .is_prefix_o(pf_a), .illegal_o(ill_a)
   );

   insn_decoder #(.FOLD_ALIAS(1'b0)) u_dut_alias (
      .insn_i(insn), .pfx_pending_i(pend), .pfx_val_i(pfx), .rs_val_i(rsv),
      .opcode_o(op_b), .rd_idx_o(rd_b), .rs_idx_o(rs_b), .rsval_o(val_b),
      .is_imm_o(imm_b), .is_prefix_o(pf_b), .illegal_o(ill_b)
   );

   // {insn, pending, op, rd, rs, rsval, imm, prefix, illegal, req}
   localparam int NV = 28;
   localparam logic [52:0] VEC [NV] = '{
      {16'h33C3, 1'b0, 5'd16, 4'd3, 4'd0, 16'h000F, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 R11
      {16'hAF6B, 1'b0, 5'd26, 4'hA, 4'd0, 16'hFFFD, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
      {16'hF83F, 1'b0, 5'd31, 4'hF, 4'd0, 16'hFFE0, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
      {16'h5140, 1'b0, 5'd16, 4'd5, 4'd1, 16'hBEEF, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
      {16'hC7E4, 1'b0, 5'd25, 4'hC, 4'd7, 16'hBEEF, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 bit 7 set
      {16'h5118, 1'b0, 5'd6,  4'd5, 4'd1, 16'hBEEF, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
      {16'h2934, 1'b0, 5'd13, 4'd2, 4'd9, 16'hBEEF, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
      {16'hFF0C, 1'b0, 5'd3,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
      {16'h1204, 1'b0, 5'd1,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
      {16'h0000, 1'b0, 5'd0,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
      {16'h3781, 1'b0, 5'd6,  4'd3, 4'd0, 16'h0078, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
      {16'h9FF1, 1'b0, 5'd6,  4'd9, 4'd0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
      {16'h4809, 1'b0, 5'd7,  4'd4, 4'd0, 16'hFF80, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
      {16'h00A5, 1'b0, 5'd8,  4'd0, 4'd0, 16'h0005, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
      {16'h8005, 1'b0, 5'd8,  4'd0, 4'd0, 16'hFC00, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
      {16'h123D, 1'b0, 5'd9,  4'd0, 4'd0, 16'h1230, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
      {16'hFFFD, 1'b1, 5'd9,  4'd0, 4'd0, 16'hFFF0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 pending ignored
      {16'h342C, 1'b0, 5'd9,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 alias 11
      {16'h5624, 1'b0, 5'd9,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
      {16'hAF6B, 1'b1, 5'd26, 4'hA, 4'd0, 16'hA5CD, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
      {16'h3781, 1'b1, 5'd6,  4'd3, 4'd0, 16'hA5C8, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
      {16'h00A5, 1'b1, 5'd8,  4'd0, 4'd0, 16'hA5C5, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
      {16'h4809, 1'b1, 5'd7,  4'd4, 4'd0, 16'hA5C0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
      {16'h5140, 1'b1, 5'd16, 4'd5, 4'd1, 16'hBEEF, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
      {16'hFF0C, 1'b1, 5'd3,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
      {16'h5136, 1'b0, 5'd0,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
      {16'h7735, 1'b0, 5'd0,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
      {16'hFFFE, 1'b1, 5'd0,  4'd0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd10}  // R10
   };

   task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d insn=%h got=%h exp=%h", req, insn, got, exp);
      end
   endtask

   initial begin
      insn = '0; pend = 1'b0; pfx = 12'hA5C; rsv = 16'hBEEF;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 R11: quiet state after reset, all-zero word is a nop
      check(3, {op_a, rd_a, rs_a, val_a, imm_a, pf_a, ill_a}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         insn = VEC[i][52:37];
         pend = VEC[i][36];
         @(negedge clk);
         check(int'(VEC[i][3:0]), {op_a, rd_a, rs_a, val_a, imm_a, pf_a, ill_a}, VEC[i][35:4]);
         // R7: the non-folding copy reports opcode 11 for the alias
         check(7, {27'd0, op_b},
               {27'd0, ((insn[1:0] == 2'b00 && insn[6:2] == 5'd11) ? 5'd11 : VEC[i][35:31])});
      end

      // R2 R9: operand tracks a new register value
      @(posedge clk);
      insn = 16'h5140; pend = 1'b1; rsv = 16'h1234;
      @(negedge clk);
      check(2, {16'd0, val_a}, {16'd0, 16'h1234});
      check(9, {16'd0, val_b}, {16'd0, 16'h1234});

      // R8: a different prefix pattern on the arithmetic immediate
      @(posedge clk);
      insn = 16'h33C3; pfx = 12'h001;
      @(negedge clk);
      check(8, {16'd0, val_a}, {16'd0, 16'h001F});

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule